// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address Filter

The block turns an oversampled asynchronous serial line into bytes or 9-bit words. A sampling front end finds the start bit and decides every bit by a 2-of-3 majority vote near the bit centre. It then checks the stop bit and hands the finished frame to an acceptance stage. That stage either writes the frame into a two-entry receive queue or drops it. A frame is dropped because the address filter rejects it or because the queue is already full. A full queue also sets a sticky overrun flag, and that flag freezes the receiver.

Software sets up the block through a 4-bit control word. The word turns the receiver on, chooses 8-bit or 9-bit frames, allows frames to be received, and switches on the address filter. On a multidrop link, the filter lets only words whose ninth bit is 1 (address words) reach the queue. The head of the queue is always visible on the output ports: the data, its ninth bit and its framing-error status. A read strobe removes the head entry. The interrupt line stays high for as long as anything is waiting in the queue.

Top module: `uarx_top`

## Requirements
- R1: After reset, all four control bits are 0, both error flags are 0, the queue is empty, and `rx_irq`, `rx_data`, `rx_bit9` and `frm_err` are all 0.
- R2: When control bit 0 (receiver on) is 0, the receiver stays idle and a complete frame on the line leaves the queue empty.
- R3: When control bit 2 (receive allowed) is 0, no frame is received even with bit 0 set.
- R4: In 8-bit mode (control bit 1 = 0), the data bits are taken least significant first. The byte appears on `rx_data` and `rx_bit9` reads 0.
- R5: In 9-bit mode (control bit 1 = 1) with the filter off, every frame is queued, and the ninth received bit appears unchanged on `rx_bit9`.
- R6: With control bit 3 (address filter) set in 9-bit mode, a frame whose ninth bit is 0 is discarded and a frame whose ninth bit is 1 is queued. In 8-bit mode, bit 3 has no effect.
- R7: A stop bit sampled as 0 stores a framing-error mark with that entry. `frm_err` shows the mark of the head entry, so it changes only when the head changes.
- R8: `rx_irq` is 1 exactly while the queue holds an entry. A pulse on `dat_rd` removes the head entry, and entries leave in arrival order. An empty queue shows 0 on the head outputs.
- R9: When an accepted frame completes while both entries are occupied, the frame is lost and `ovr_err` sets. While the flag is set, no frame is loaded, but held entries can still be read. Only a control write with bit 2 = 0 clears the flag.
- R10: Each bit takes 16 samples, and samples 7, 8 and 9 are put to a 2-of-3 majority vote. A one-sample glitch inside that window does not change the received bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| os_tick | input | 1 | One-cycle pulse, 16 per bit time |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | Control word: bit0 on, bit1 9-bit, bit2 receive allowed, bit3 address filter |
| dat_rd | input | 1 | Pop the head entry of the queue |
| rx_data | output | 8 | Data of the head entry |
| rx_bit9 | output | 1 | Ninth bit of the head entry |
| frm_err | output | 1 | Framing-error mark of the head entry |
| ovr_err | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | High while the queue is not empty |

## Verification
The assertions take for granted that `os_tick` is a single-cycle pulse spaced further apart than the line synchronizer is deep. They also take for granted that the control word is rewritten only between frames, so a frame never sees its mode change halfway through. The stimulus produces a tick on every fourth clock. Control writes and reads are issued only while the line is idle. The line level is held for whole tick periods, apart from the deliberate one-tick glitch used for R10.

// File: rtl/uarx_pkg.sv
package uarx_pkg;

  localparam int CTL_W = 4;

  // control word, bit 0 is the LSB of the written value
  typedef struct packed {
    logic adden;  // bit 3: address filter
    logic cont;   // bit 2: receive allowed
    logic nine;   // bit 1: 9-bit frames
    logic en;     // bit 0: receiver on
  } ctl_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic addr_reject(input ctl_t c, input logic b9);
    return c.nine && c.adden && !b9;
  endfunction

endpackage

// File: rtl/uarx_ctrl.sv
module uarx_ctrl
  import uarx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             ovr_set,
  output ctl_t             ctl_q,
  output logic             ovr_q,
  output logic             run
);

  ctl_t wr_word;
  assign wr_word = ctl_t'(ctl_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (ctl_wr) ctl_q <= wr_word;
      if (ctl_wr && !wr_word.cont) ovr_q <= 1'b0;
      else if (ovr_set)            ovr_q <= 1'b1;
    end
  end

  assign run = ctl_q.en && ctl_q.cont && !ovr_q;

endmodule

// File: rtl/uarx_sampler.sv
module uarx_sampler #(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              nine_i,
  input  logic              rxd_s,
  input  logic              tick,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] done_data,
  output logic              done_b9,
  output logic              done_ferr
);

  localparam int CW   = $clog2(OSR);
  localparam int IW   = $clog2(DATA_W + 2);
  localparam int SW   = DATA_W + 1;
  localparam logic [CW-1:0] S_A  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] S_B  = CW'(OSR/2);
  localparam logic [CW-1:0] S_C  = CW'(OSR/2 + 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} st_e;

  st_e            st;
  logic [CW-1:0]  cnt;
  logic           smp_a, smp_b;
  logic [IW-1:0]  idx;
  logic [SW-1:0]  sr;
  logic           nine_l;
  logic           decide, vote, bit_end;
  logic [IW-1:0]  nbits;

  assign vote    = uarx_pkg::maj3(smp_a, smp_b, rxd_s);
  assign decide  = tick && (st != ST_IDLE) && (cnt == S_C);
  assign bit_end = tick && (st != ST_IDLE) && (cnt == LAST);
  assign nbits   = nine_l ? IW'(DATA_W + 1) : IW'(DATA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      smp_a  <= 1'b1;
      smp_b  <= 1'b1;
      idx    <= '0;
      sr     <= '0;
      nine_l <= 1'b0;
    end else if (!run) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (tick) begin
      if (st == ST_IDLE) begin
        if (!rxd_s) begin
          st     <= ST_START;
          cnt    <= CW'(1);
          nine_l <= nine_i;
          sr     <= '0;
          idx    <= '0;
        end
      end else begin
        cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
        if (cnt == S_A) smp_a <= rxd_s;
        if (cnt == S_B) smp_b <= rxd_s;
        unique case (st)
          ST_START: begin
            if (decide && vote)  st <= ST_IDLE;
            else if (bit_end)    st <= ST_DATA;
          end
          ST_DATA: begin
            if (decide) begin
              sr[idx] <= vote;
              idx     <= idx + IW'(1);
            end
            if (bit_end && idx == nbits) st <= ST_STOP;
          end
          ST_STOP: begin
            if (decide) st <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy      = (st != ST_IDLE);
  assign done      = run && decide && (st == ST_STOP);
  assign done_data = sr[DATA_W-1:0];
  assign done_b9   = nine_l && sr[DATA_W];
  assign done_ferr = !vote;

endmodule

// File: rtl/uarx_accept.sv
module uarx_accept
  import uarx_pkg::*;
(
  input  logic done,
  input  logic b9,
  input  ctl_t ctl,
  input  logic full,
  output logic push,
  output logic ovr_set
);

  logic wanted;
  assign wanted  = done && !addr_reject(ctl, b9);
  assign push    = wanted && !full;
  assign ovr_set = wanted && full;

endmodule

// File: rtl/uarx_fifo.sv
module uarx_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       mem[g] <= '0;
      else if (push && wp == AW'(g))    mem[g] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      unique case ({push, pop})
        2'b10:   cnt <= cnt + (AW+1)'(1);
        2'b01:   cnt <= cnt - (AW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign head  = empty ? '0 : mem[rp];

endmodule

// File: rtl/uarx_top.sv
module uarx_top
  import uarx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int FIFO_DEPTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              os_tick,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              dat_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              frm_err,
  output logic              ovr_err,
  output logic              rx_irq
);

  localparam int ENT_W = DATA_W + 2;

  // line synchronizer
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rxd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end
  assign rxd_s = sync_q[SYNC_STAGES-1];

  // named internal events
  ctl_t              ctl_q;
  logic              rx_run;
  logic              rx_busy;
  logic              frame_done;
  logic [DATA_W-1:0] frame_data;
  logic              frame_b9;
  logic              frame_ferr;
  logic              push_evt;
  logic              pop_evt;
  logic              ovr_set;
  logic              fifo_empty;
  logic              fifo_full;
  logic [ENT_W-1:0]  fifo_head;

  uarx_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .ovr_set   (ovr_set),
    .ctl_q     (ctl_q),
    .ovr_q     (ovr_err),
    .run       (rx_run)
  );

  uarx_sampler #(.OSR(OSR), .DATA_W(DATA_W)) u_smp (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (rx_run),
    .nine_i    (ctl_q.nine),
    .rxd_s     (rxd_s),
    .tick      (os_tick),
    .busy      (rx_busy),
    .done      (frame_done),
    .done_data (frame_data),
    .done_b9   (frame_b9),
    .done_ferr (frame_ferr)
  );

  uarx_accept u_acc (
    .done    (frame_done),
    .b9      (frame_b9),
    .ctl     (ctl_q),
    .full    (fifo_full),
    .push    (push_evt),
    .ovr_set (ovr_set)
  );

  assign pop_evt = dat_rd && !fifo_empty;

  uarx_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_evt),
    .wdata ({frame_ferr, frame_b9, frame_data}),
    .pop   (pop_evt),
    .head  (fifo_head),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  assign rx_data = fifo_head[DATA_W-1:0];
  assign rx_bit9 = fifo_head[DATA_W];
  assign frm_err = fifo_head[DATA_W+1];
  assign rx_irq  = !fifo_empty;

endmodule

// File: rtl/uarx_chk.sv
module uarx_chk (
  input logic clk,
  input logic rst_n,
  input logic ctl_wr,
  input logic ctl_wcont,
  input logic ovr_err,
  input logic rx_irq,
  input logic push_evt,
  input logic pop_evt,
  input logic fifo_full,
  input logic frame_done,
  input logic frame_b9,
  input logic mode_nine,
  input logic mode_adden,
  input logic rx_en,
  input logic rx_busy
);

  // R8: a load always leaves something pending
  p_irq_on_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |=> rx_irq);

  // R9: no load into a full queue without a simultaneous pop
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !(push_evt && !pop_evt));

  // R9: overrun stays until a write clears receive-allowed
  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && !(ctl_wr && !ctl_wcont)) |=> ovr_err);

  // R9: overrun only rises out of a full queue
  p_ovr_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $past(fifo_full));

  // R9: nothing is loaded while overrun is pending
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err |-> !push_evt);

  // R6: filtered data words never reach the queue
  p_addr_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && mode_nine && mode_adden && !frame_b9) |-> !push_evt);

  // R2: a receiver switched off stays idle
  p_idle_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && $past(!rx_en)) |-> !rx_busy);

endmodule

bind uarx_top uarx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr     (ctl_wr),
  .ctl_wcont  (ctl_wdata[2]),
  .ovr_err    (ovr_err),
  .rx_irq     (rx_irq),
  .push_evt   (push_evt),
  .pop_evt    (pop_evt),
  .fifo_full  (fifo_full),
  .frame_done (frame_done),
  .frame_b9   (frame_b9),
  .mode_nine  (ctl_q.nine),
  .mode_adden (ctl_q.adden),
  .rx_en      (ctl_q.en),
  .rx_busy    (rx_busy)
);

// File: tb/uarx_top_tb.sv
module uarx_top_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       os_tick;
  logic       ctl_wr = 1'b0;
  logic [3:0] ctl_wdata = 4'h0;
  logic       dat_rd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9, frm_err, ovr_err, rx_irq;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;
  logic [9:0] expq[$];
  logic [1:0] div = 2'd0;

  always #4 clk = ~clk;   // 125 MHz

  always @(negedge clk) div <= div + 2'd1;
  assign os_tick = (div == 2'd0);

  uarx_top u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .dat_rd(dat_rd),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .frm_err(frm_err),
    .ovr_err(ovr_err), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic one_tick(input logic v);
    rxd = v;
    repeat (4) @(negedge clk);
  endtask

  // start, nb data bits LSB first, stop; optional one-tick glitch at sample 8 of bit gbit
  task automatic send_frame(input logic [8:0] d, input int nb, input logic stop_v, input int gbit);
    for (int t = 0; t < 16; t++) one_tick(1'b0);
    for (int b = 0; b < nb; b++)
      for (int t = 0; t < 16; t++) one_tick((b == gbit && t == 8) ? ~d[b] : d[b]);
    for (int t = 0; t < 16; t++) one_tick(stop_v);
    for (int t = 0; t < 8; t++) one_tick(1'b1);
  endtask

  task automatic wr_ctl(input logic [3:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // driver side: record what the frame must produce
  task automatic push_exp(input logic ferr, input logic b9, input logic [7:0] d);
    expq.push_back({ferr, b9, d});
  endtask

  // monitor side: compare head with the oldest expectation, then pop
  task automatic read_check(input string req);
    logic [9:0] e;
    @(negedge clk);
    if (expq.size() == 0) begin
      chk({req, " scoreboard underflow"}, 32'd1, 32'd0);
    end else begin
      e = expq.pop_front();
      chk({req, " irq"}, 32'(rx_irq), 32'd1);
      chk({req, " head"}, 32'({frm_err, rx_bit9, rx_data}), 32'(e));
    end
    dat_rd = 1'b1;
    @(negedge clk);
    dat_rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(rx_irq), 0);
    chk("R1 ovr", 32'(ovr_err), 0);
    chk("R1 head", 32'({frm_err, rx_bit9, rx_data}), 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R1 irq after release", 32'(rx_irq), 0);

    // R2 receiver off, receive allowed
    wr_ctl(4'h4);
    send_frame(9'h0A5, 8, 1'b1, -1);
    chk("R2 off ignores line", 32'(rx_irq), 0);

    // R3 receiver on, receive not allowed
    wr_ctl(4'h1);
    send_frame(9'h0A5, 8, 1'b1, -1);
    chk("R3 not allowed ignores line", 32'(rx_irq), 0);

    // R4 8-bit, LSB first
    wr_ctl(4'h5);
    send_frame(9'h03C, 8, 1'b1, -1);
    push_exp(1'b0, 1'b0, 8'h3C);
    read_check("R4 8-bit frame");
    chk("R8 irq low when empty", 32'(rx_irq), 0);
    chk("R8 empty head zero", 32'({frm_err, rx_bit9, rx_data}), 0);

    // R10 single-sample glitches
    send_frame(9'h096, 8, 1'b1, 2);
    push_exp(1'b0, 1'b0, 8'h96);
    read_check("R10 glitch on a one bit");
    send_frame(9'h096, 8, 1'b1, 0);
    push_exp(1'b0, 1'b0, 8'h96);
    read_check("R10 glitch on a zero bit");

    // R5 9-bit, filter off: ninth bit passes, order kept (R8)
    wr_ctl(4'h7);
    send_frame(9'h15A, 9, 1'b1, -1);
    push_exp(1'b0, 1'b1, 8'h5A);
    send_frame(9'h081, 9, 1'b1, -1);
    push_exp(1'b0, 1'b0, 8'h81);
    read_check("R5 ninth bit one");
    read_check("R5 R8 ninth bit zero second in order");

    // R6 filter on in 9-bit mode
    wr_ctl(4'hF);
    send_frame(9'h011, 9, 1'b1, -1);
    chk("R6 data word dropped", 32'(rx_irq), 0);
    send_frame(9'h122, 9, 1'b1, -1);
    push_exp(1'b0, 1'b1, 8'h22);
    read_check("R6 address word kept");
    // R6 filter has no effect in 8-bit mode
    wr_ctl(4'hD);
    send_frame(9'h044, 8, 1'b1, -1);
    push_exp(1'b0, 1'b0, 8'h44);
    read_check("R6 filter ignored in 8-bit");

    // R7 framing error follows the head entry
    wr_ctl(4'h5);
    send_frame(9'h055, 8, 1'b0, -1);
    send_frame(9'h066, 8, 1'b1, -1);
    push_exp(1'b1, 1'b0, 8'h55);
    push_exp(1'b0, 1'b0, 8'h66);
    read_check("R7 bad stop marked");
    read_check("R7 next entry clean");

    // R9 overrun
    send_frame(9'h001, 8, 1'b1, -1);
    send_frame(9'h002, 8, 1'b1, -1);
    chk("R9 no overrun at two", 32'(ovr_err), 0);
    send_frame(9'h003, 8, 1'b1, -1);
    chk("R9 overrun set", 32'(ovr_err), 1);
    push_exp(1'b0, 1'b0, 8'h01);
    read_check("R9 held entry readable");
    send_frame(9'h004, 8, 1'b1, -1);
    push_exp(1'b0, 1'b0, 8'h02);
    read_check("R9 third frame lost");
    chk("R9 stalled no load", 32'(rx_irq), 0);
    chk("R9 flag still set", 32'(ovr_err), 1);
    wr_ctl(4'h7);
    chk("R9 write keeping bit2 leaves flag", 32'(ovr_err), 1);
    wr_ctl(4'h1);
    chk("R9 cleared by bit2 low", 32'(ovr_err), 0);
    wr_ctl(4'h5);
    send_frame(9'h007, 8, 1'b1, -1);
    push_exp(1'b0, 1'b0, 8'h07);
    read_check("R9 receives again");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule